// File: doc/BRIEF.md
# Grouped Event Code Selector

This block sits between a field of raw hardware event lines and a bank of event counters. The raw events are laid out as a two-dimensional array: eight groups, each offering up to 256 event codes. A shared 64-bit selection register picks one active code per group and carries a global enable bit. Each counter lane then chooses, through its own type register, which group it follows. A per-lane source filter qualifies the event by subunit and by originating requester. The lane emits a registered one-cycle increment strobe to its counter.

Only one code per group can be live at any time, so any number of lanes may tap the same group, but every such lane sees the same selected code. A reserved type value turns a lane into a plain cycle counter that bypasses the group scheme. The counters themselves and any read path sit outside this block. Software reaches it through a simple write port with per-byte enables.

Top module: `grouped_event_select`

## Requirements
- R1: While reset is held and after it is released, all increment strobes are 0, the global enable is clear, every filter is clear and every lane's type register reads 0xFF, which selects no source.
- R2: The selection register sits at address 0x410. Group g (0..6) keeps its 8-bit code in data bits 8g+7..8g. Group 7 keeps a 7-bit code in bits 62..56 with its code MSB held at 0. Bit 63 is the global enable. Byte enable bit b guards data bits 8b+7..8b, so byte 7 writes both the group 7 code and the enable.
- R3: A selection register write with byte enable bit g clear leaves group g's code unchanged.
- R4: Lane k's type register is at 0x424 + 0x10*k and takes data bits 7..0. Its filter register is at 0x423 + 0x10*k and takes the subunit mask from bits 19..17, the origin mask from bits 1..0 and the no-ID admit bit from bit 2. Byte enables apply only to the selection register.
- R5: For a lane whose type t is 0..7, the strobe in cycle n+1 equals raw_evt[t*256 + code_t] AND the filter result AND the global enable, all sampled in cycle n.
- R6: The filter passes when the group's one-hot subunit tag meets the subunit mask, and either the one-hot origin tag meets the origin mask or the group's no-ID flag is set together with the admit bit.
- R7: With the global enable clear, every strobe is 0 one cycle later, cycle lanes included.
- R8: A type value above 7 other than 0xFE selects nothing, and that lane never strobes.
- R9: A lane of type 0xFE strobes in every cycle that follows a cycle with the global enable set, regardless of raw events and filter.
- R10: Several lanes following the same group all strobe on that group's single selected code.
- R11: An event present in the same cycle as a write to its group's code is judged against the old code. Events in the next cycle are judged against the new code.
- R12: Writes to addresses outside the mapped registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write address |
| wr_be | input | 8 | Byte enables for the selection register |
| wr_data | input | 64 | Register write data |
| raw_evt | input | 2048 | Raw event strobes, index group*256 + code |
| evt_sub | input | 24 | One-hot subunit tag per group, 3 bits each |
| evt_org | input | 16 | One-hot origin tag per group, 2 bits each |
| evt_noid | input | 8 | Per-group flag marking an ID-independent event |
| cnt_inc | output | NUM_CTRS (4) | Registered increment strobe per counter lane |

## Verification
A register write and event capture can fall on the same clock edge. When the write changes the code of the group an event belongs to, the event must still be judged against the code held before the write. The bench provokes this by placing a raw event at a group's current code in the very cycle that a write retargets that group. It expects the strobe one cycle later. It then drives the same old code again and expects no strobe, and drives the new code and expects one. A byte-7 write that disables counting while a cycle lane is active is judged the same way: the lane still strobes for the write cycle and is silent afterwards.

// File: rtl/evsel_pkg.sv
// Package: shared constants, register layout and type decoding for the
// grouped event selector. Assumes eight groups, so that one byte lane of
// the 64-bit selection register carries exactly one group's code.
package evsel_pkg;

    localparam int GROUPS   = 8;
    localparam int GRP_W    = $clog2(GROUPS);
    localparam int CODE_W   = 8;
    localparam int CODES    = 1 << CODE_W;
    localparam int SUB_W    = 3;
    localparam int ORG_W    = 2;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 64;
    localparam int BE_W     = DATA_W / 8;
    localparam int TYPE_W   = 8;
    localparam int RAW_W    = GROUPS * CODES;

    // register map
    localparam logic [ADDR_W-1:0] SEL_ADDR   = 12'h410;
    localparam logic [ADDR_W-1:0] FILT_BASE  = 12'h423;
    localparam logic [ADDR_W-1:0] TYPE_BASE  = 12'h424;
    localparam logic [ADDR_W-1:0] CTR_STRIDE = 12'h010;

    // field positions
    localparam int EN_BIT   = DATA_W - 1;
    localparam int SUB_LSB  = 17;
    localparam int ORG_LSB  = 0;
    localparam int NOID_BIT = 2;

    localparam logic [TYPE_W-1:0] TYPE_CYCLES = 8'hFE;
    localparam logic [TYPE_W-1:0] TYPE_NONE   = 8'hFF;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [ORG_W-1:0] org;
        logic             noid;
    } filt_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_GROUP  = 2'd1,
        SRC_CYCLES = 2'd2
    } src_e;

    // Classify a type register value into the source it selects.
    function automatic src_e decode_type(input logic [TYPE_W-1:0] t);
        if (t < TYPE_W'(GROUPS))
            return SRC_GROUP;
        else if (t == TYPE_CYCLES)
            return SRC_CYCLES;
        else
            return SRC_NONE;
    endfunction

endpackage

// File: rtl/evsel_regs.sv
// Register file: the shared selection register (one code per group plus a
// global enable) and one type and one filter register per counter lane.
// Assumes single-cycle writes; byte enables guard only the selection
// register, lane registers are written whole.
module evsel_regs
    import evsel_pkg::*;
#(
    parameter int NUM_CTRS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [BE_W-1:0]            wr_be,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [GROUPS*CODE_W-1:0]   code_flat,
    output logic                       sel_en,
    output logic [NUM_CTRS*TYPE_W-1:0] typ_flat,
    output filt_t [NUM_CTRS-1:0]       filt
);

    logic sel_hit;
    logic en_q;

    // Decode a write to the selection register.
    always_comb sel_hit = wr_en && (wr_addr == SEL_ADDR);

    // Global enable lives in the top bit of the last byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (sel_hit && wr_be[BE_W-1])
            en_q <= wr_data[EN_BIT];
    end

    assign sel_en = en_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_code
        // the last group shares its byte with the enable bit
        localparam int FW = (g == GROUPS - 1) ? CODE_W - 1 : CODE_W;
        logic [FW-1:0] field_q;

        // Per-group code field, updated only under its byte enable.
        always_ff @(posedge clk) begin
            if (!rst_n)
                field_q <= '0;
            else if (sel_hit && wr_be[g])
                field_q <= wr_data[g*CODE_W +: FW];
        end

        assign code_flat[g*CODE_W +: CODE_W] = CODE_W'(field_q);
    end

    for (genvar k = 0; k < NUM_CTRS; k++) begin : g_lane
        localparam logic [ADDR_W-1:0] T_ADDR = TYPE_BASE + ADDR_W'(k) * CTR_STRIDE;
        localparam logic [ADDR_W-1:0] F_ADDR = FILT_BASE + ADDR_W'(k) * CTR_STRIDE;
        logic [TYPE_W-1:0] typ_q;
        filt_t             filt_q;

        // Lane type register: which group (or cycles) this lane follows.
        always_ff @(posedge clk) begin
            if (!rst_n)
                typ_q <= TYPE_NONE;
            else if (wr_en && (wr_addr == T_ADDR))
                typ_q <= wr_data[TYPE_W-1:0];
        end

        // Lane filter register: subunit mask, origin mask, no-ID admit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                filt_q <= '0;
            else if (wr_en && (wr_addr == F_ADDR)) begin
                filt_q.sub  <= wr_data[SUB_LSB +: SUB_W];
                filt_q.org  <= wr_data[ORG_LSB +: ORG_W];
                filt_q.noid <= wr_data[NOID_BIT];
            end
        end

        assign typ_flat[k*TYPE_W +: TYPE_W] = typ_q;
        assign filt[k] = filt_q;
    end

endmodule

// File: rtl/evsel_group_mux.sv
// Group code multiplexer: for each group, picks the one raw event line
// named by that group's selected code. Purely combinational and shared
// by all counter lanes. Assumes raw_evt is laid out group-major.
module evsel_group_mux
    import evsel_pkg::*;
(
    input  logic [RAW_W-1:0]         raw_evt,
    input  logic [GROUPS*CODE_W-1:0] code_flat,
    output logic [GROUPS-1:0]        grp_hit
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_sel
        logic [CODES-1:0]  row;
        logic [CODE_W-1:0] code;

        // Select this group's row of event lines and its active code.
        always_comb begin
            row         = raw_evt[g*CODES +: CODES];
            code        = code_flat[g*CODE_W +: CODE_W];
            grp_hit[g]  = row[code];
        end
    end

endmodule

// File: rtl/evsel_lane.sv
// Counter lane: routes the chosen group's selected event through the
// lane's source filter and registers it as a one-cycle increment strobe.
// Assumes the subunit and origin tags are one-hot per group.
module evsel_lane
    import evsel_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_en,
    input  logic [TYPE_W-1:0]       typ,
    input  filt_t                   filt,
    input  logic [GROUPS-1:0]       grp_hit,
    input  logic [GROUPS*SUB_W-1:0] evt_sub,
    input  logic [GROUPS*ORG_W-1:0] evt_org,
    input  logic [GROUPS-1:0]       evt_noid,
    output logic                    inc
);

    src_e             src;
    logic [GRP_W-1:0] gi;
    logic [SUB_W-1:0] sub_g;
    logic [ORG_W-1:0] org_g;
    logic             noid_g;
    logic             pass;
    logic             nxt;
    logic             inc_q;

    // Decode the lane source and gather the followed group's tags.
    always_comb begin
        src    = decode_type(typ);
        gi     = typ[GRP_W-1:0];
        sub_g  = evt_sub[gi*SUB_W +: SUB_W];
        org_g  = evt_org[gi*ORG_W +: ORG_W];
        noid_g = evt_noid[gi];
    end

    // Source filter: subunit must match, and origin or no-ID admit.
    always_comb begin
        pass = (|(sub_g & filt.sub)) &&
               ((|(org_g & filt.org)) || (noid_g && filt.noid));
    end

    // Next strobe value from the selected source under the global enable.
    always_comb begin
        unique case (src)
            SRC_GROUP:  nxt = grp_hit[gi] && pass;
            SRC_CYCLES: nxt = 1'b1;
            default:    nxt = 1'b0;
        endcase
        nxt = nxt && sel_en;
    end

    // Register the strobe once so it trails the raw event by a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inc_q <= 1'b0;
        else
            inc_q <= nxt;
    end

    assign inc = inc_q;

endmodule

// File: rtl/grouped_event_select.sv
// Top of the grouped event selector: register file, shared per-group code
// multiplexer and one filter/strobe lane per counter. Assumes the counter
// bank downstream consumes cnt_inc directly, one strobe per cycle.
module grouped_event_select
    import evsel_pkg::*;
#(
    parameter int NUM_CTRS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BE_W-1:0]         wr_be,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [RAW_W-1:0]        raw_evt,
    input  logic [GROUPS*SUB_W-1:0] evt_sub,
    input  logic [GROUPS*ORG_W-1:0] evt_org,
    input  logic [GROUPS-1:0]       evt_noid,
    output logic [NUM_CTRS-1:0]     cnt_inc
);

    logic [GROUPS*CODE_W-1:0]   code_flat;
    logic                       sel_en;
    logic [NUM_CTRS*TYPE_W-1:0] typ_flat;
    filt_t [NUM_CTRS-1:0]       filt;
    logic [GROUPS-1:0]          grp_hit;

    evsel_regs #(
        .NUM_CTRS (NUM_CTRS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .code_flat (code_flat),
        .sel_en    (sel_en),
        .typ_flat  (typ_flat),
        .filt      (filt)
    );

    evsel_group_mux u_mux (
        .raw_evt   (raw_evt),
        .code_flat (code_flat),
        .grp_hit   (grp_hit)
    );

    for (genvar k = 0; k < NUM_CTRS; k++) begin : g_lane
        evsel_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_en   (sel_en),
            .typ      (typ_flat[k*TYPE_W +: TYPE_W]),
            .filt     (filt[k]),
            .grp_hit  (grp_hit),
            .evt_sub  (evt_sub),
            .evt_org  (evt_org),
            .evt_noid (evt_noid),
            .inc      (cnt_inc[k])
        );
    end

endmodule

// File: rtl/grouped_event_select_chk.sv
// Checker for the grouped event selector, bound to the top module.
// Observes register state and strobes; drives nothing.
module grouped_event_select_chk
    import evsel_pkg::*;
#(
    parameter int NUM_CTRS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [BE_W-1:0]            wr_be,
    input logic                       sel_en,
    input logic [GROUPS*CODE_W-1:0]   code_flat,
    input logic [NUM_CTRS*TYPE_W-1:0] typ_flat,
    input logic [NUM_CTRS-1:0]        cnt_inc
);

    // R1: reset leaves strobes low and counting disabled
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_inc == '0) && !sel_en);

    // R7: a clear global enable silences every lane next cycle
    assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |=> (cnt_inc == '0));

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        // R3: a selection write without this group's byte keeps its code
        assert_field_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == SEL_ADDR) && !wr_be[g])
            |=> $stable(code_flat[g*CODE_W +: CODE_W]));
    end

    for (genvar k = 0; k < NUM_CTRS; k++) begin : g_ctr
        // R8: a type with no source never produces a strobe
        assert_no_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((typ_flat[k*TYPE_W +: TYPE_W] >= TYPE_W'(GROUPS)) &&
             (typ_flat[k*TYPE_W +: TYPE_W] != TYPE_CYCLES))
            |=> !cnt_inc[k]);

        // R9: an enabled cycle lane strobes in the following cycle
        assert_cycle_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_en && (typ_flat[k*TYPE_W +: TYPE_W] == TYPE_CYCLES))
            |=> cnt_inc[k]);
    end

endmodule

bind grouped_event_select grouped_event_select_chk #(
    .NUM_CTRS (NUM_CTRS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_be     (wr_be),
    .sel_en    (sel_en),
    .code_flat (code_flat),
    .typ_flat  (typ_flat),
    .cnt_inc   (cnt_inc)
);

// File: tb/grouped_event_select_bench.sv
module grouped_event_select_bench;
    import evsel_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCTR       = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    wr_en = 1'b0;
    logic [ADDR_W-1:0]       wr_addr = '0;
    logic [BE_W-1:0]         wr_be = '0;
    logic [DATA_W-1:0]       wr_data = '0;
    logic [RAW_W-1:0]        raw_evt = '0;
    logic [GROUPS*SUB_W-1:0] evt_sub = '0;
    logic [GROUPS*ORG_W-1:0] evt_org = '0;
    logic [GROUPS-1:0]       evt_noid = '0;
    logic [NCTR-1:0]         cnt_inc;

    int n_chk = 0;
    int n_err = 0;

    // shadow of the programmed state, updated from the written values
    logic [7:0] m_code [GROUPS];
    logic       m_en;
    logic [7:0] m_typ  [NCTR];
    logic [2:0] m_sub  [NCTR];
    logic [1:0] m_org  [NCTR];
    logic       m_noid [NCTR];

    // current stimulus
    int         cur_g;
    int         cur_c;
    bit         cur_v;
    bit         cur_all;
    logic [2:0] cur_sub;
    logic [1:0] cur_org;
    logic       cur_noid;

    grouped_event_select #(.NUM_CTRS(NCTR)) u_grouped_event_select (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .raw_evt(raw_evt),
        .evt_sub(evt_sub), .evt_org(evt_org), .evt_noid(evt_noid),
        .cnt_inc(cnt_inc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [7:0] be, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        tick();
        wr_en = 1'b0;
        if (a == 12'h410) begin
            for (int g = 0; g < GROUPS; g++)
                if (be[g]) m_code[g] = (g == 7) ? (d[g*8 +: 8] & 8'h7F) : d[g*8 +: 8];
            if (be[7]) m_en = d[63];
        end
        for (int k = 0; k < NCTR; k++) begin
            if (a == 12'h424 + 12'(k*16)) m_typ[k] = d[7:0];
            if (a == 12'h423 + 12'(k*16)) begin
                m_sub[k] = d[19:17]; m_org[k] = d[1:0]; m_noid[k] = d[2];
            end
        end
    endtask

    task automatic set_types(input logic [7:0] t0, input logic [7:0] t1,
                             input logic [7:0] t2, input logic [7:0] t3);
        wr_reg(12'h424, 8'h00, {56'd0, t0});
        wr_reg(12'h434, 8'h00, {56'd0, t1});
        wr_reg(12'h444, 8'h00, {56'd0, t2});
        wr_reg(12'h454, 8'h00, {56'd0, t3});
    endtask

    task automatic drive_evt(input int g, input int c, input bit v,
                             input logic [2:0] s, input logic [1:0] o, input logic n);
        raw_evt = '0;
        if (v) raw_evt[g*CODES + c] = 1'b1;
        evt_sub = {GROUPS{s}}; evt_org = {GROUPS{o}}; evt_noid = {GROUPS{n}};
        cur_g = g; cur_c = c; cur_v = v; cur_all = 1'b0;
        cur_sub = s; cur_org = o; cur_noid = n;
    endtask

    task automatic drive_all();
        raw_evt = '1; evt_sub = '1; evt_org = '1; evt_noid = '1;
        cur_all = 1'b1; cur_v = 1'b0; cur_sub = 3'b111; cur_org = 2'b11; cur_noid = 1'b1;
    endtask

    function automatic logic [NCTR-1:0] exp_vec();
        logic [NCTR-1:0] e;
        logic hit;
        logic pass;
        for (int k = 0; k < NCTR; k++) begin
            e[k] = 1'b0;
            if (m_en) begin
                if (m_typ[k] == 8'hFE) e[k] = 1'b1;
                else if (m_typ[k] < 8) begin
                    hit  = cur_all || (cur_v && (int'(m_typ[k]) == cur_g) &&
                                       (int'(m_code[m_typ[k]]) == cur_c));
                    pass = (|(cur_sub & m_sub[k])) &&
                           ((|(cur_org & m_org[k])) || (cur_noid && m_noid[k]));
                    e[k] = hit && pass;
                end
            end
        end
        return e;
    endfunction

    task automatic check(input string tag, input logic [NCTR-1:0] e);
        n_chk++;
        if (cnt_inc !== e) begin
            n_err++;
            $display("FAIL %s: cnt_inc=%b expected %b", tag, cnt_inc, e);
        end
    endtask

    task automatic evt_check(input string tag, input int g, input int c,
                             input logic [2:0] s, input logic [1:0] o, input logic n);
        drive_evt(g, c, 1'b1, s, o, n);
        tick();
        check(tag, exp_vec());
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [63:0] sel;
        logic [NCTR-1:0] e;
        for (int g = 0; g < GROUPS; g++) m_code[g] = '0;
        m_en = 1'b0;
        for (int k = 0; k < NCTR; k++) begin
            m_typ[k] = 8'hFF; m_sub[k] = '0; m_org[k] = '0; m_noid[k] = 1'b0;
        end

        // R1: strobes stay low under reset even with every event asserted
        drive_all();
        repeat (4) tick();
        check("R1 in reset", '0);
        rst_n = 1'b1;
        tick(); tick();
        check("R1 after reset", '0);

        // R2: program all codes; group 7 byte 0x87 gives enable + code 0x07
        for (int g = 0; g < GROUPS; g++) sel[g*8 +: 8] = 8'(8'h10 + g * 8'h11);
        wr_reg(12'h410, 8'hFF, sel);
        // R4: filters at 0x423 + 0x10*k
        wr_reg(12'h423, 8'h00, (64'd7 << 17) | 64'd7);
        wr_reg(12'h433, 8'h00, (64'd1 << 17) | 64'd1);
        wr_reg(12'h443, 8'h00, (64'd7 << 17) | 64'd7);
        wr_reg(12'h453, 8'h00, (64'd2 << 17) | 64'd4);

        // R4 R5 R6 R8 R9: sweep groups, code hits/misses and filter tags
        for (int g = 0; g < GROUPS; g++) begin
            set_types(8'(g), 8'(g), 8'((g + 1) % 8),
                      (g == 7) ? 8'hFE : ((g % 2) == 1) ? 8'(8 + g) : 8'(g));
            for (int tc = 0; tc < 4; tc++) begin
                for (int a = 0; a < 12; a++) begin
                    int eg;
                    int ec;
                    eg = (tc == 2) ? (g + 1) % 8 : g;
                    ec = (tc == 0) ? int'(m_code[g]) :
                         (tc == 1) ? int'(m_code[g] ^ 8'h01) :
                         (tc == 2) ? int'(m_code[eg]) : int'(m_code[g] | 8'h80);
                    if (tc == 3 && g != 7) ec = int'(m_code[g] ^ 8'h80);
                    evt_check("R5 R6 sweep", eg, ec, 3'(1 << (a % 3)),
                              2'(1 << ((a / 3) % 2)), 1'(a / 6));
                end
            end
        end

        // R2: group 7 code MSB held at 0 (event 0x87 misses, 0x07 hits)
        set_types(8'd7, 8'hFF, 8'hFF, 8'hFF);
        evt_check("R2 g7 high code", 7, 8'h87, 3'b111, 2'b11, 1'b1);
        if (cnt_inc[0] !== 1'b0) begin n_err++; $display("FAIL R2: got %b expected 0", cnt_inc[0]); end
        n_chk++;
        evt_check("R2 g7 low code", 7, 8'h07, 3'b111, 2'b11, 1'b1);

        // R5: full code sweep on group 0
        set_types(8'd0, 8'hFF, 8'hFF, 8'hFF);
        for (int c = 0; c < CODES; c++)
            evt_check("R5 code sweep", 0, c, 3'b111, 2'b11, 1'b1);

        // R3: rewrite group 2 only, group 5 keeps its code
        wr_reg(12'h410, 8'b0000_0100, 64'hFFFF_FFFF_FF5A_FFFF);
        set_types(8'd2, 8'd5, 8'hFF, 8'hFF);
        evt_check("R3 new code", 2, 8'h5A, 3'b001, 2'b01, 1'b0);
        evt_check("R3 old code gone", 2, 8'h32, 3'b001, 2'b01, 1'b0);
        evt_check("R3 other group kept", 5, 8'h65, 3'b001, 2'b01, 1'b0);
        if (cnt_inc[1] !== 1'b1) begin n_err++; $display("FAIL R3: got %b expected 1", cnt_inc[1]); end
        n_chk++;

        // R10: three lanes on group 4 share its single code
        set_types(8'd4, 8'd4, 8'd4, 8'hFF);
        evt_check("R10 shared", 4, 8'h54, 3'b001, 2'b01, 1'b0);
        if (cnt_inc !== 4'b0111) begin n_err++; $display("FAIL R10: got %b expected 0111", cnt_inc); end
        n_chk++;

        // R11: event at old code in the same cycle as the code write
        drive_evt(4, 8'h54, 1'b1, 3'b001, 2'b01, 1'b0);
        e = exp_vec();
        wr_reg(12'h410, 8'b0001_0000, 64'h0000_00C3_0000_0000);
        check("R11 old code in write cycle", e);
        evt_check("R11 old code after", 4, 8'h54, 3'b001, 2'b01, 1'b0);
        evt_check("R11 new code after", 4, 8'hC3, 3'b001, 2'b01, 1'b0);

        // R12: unmapped writes change nothing
        drive_evt(0, 0, 1'b0, 3'b000, 2'b00, 1'b0);
        wr_reg(12'h411, 8'hFF, 64'd0);
        wr_reg(12'h425, 8'hFF, 64'd0);
        wr_reg(12'h464, 8'hFF, 64'd0);
        wr_reg(12'h40F, 8'hFF, 64'd0);
        evt_check("R12 unmapped", 4, 8'hC3, 3'b001, 2'b01, 1'b0);
        if (cnt_inc !== 4'b0111) begin n_err++; $display("FAIL R12: got %b expected 0111", cnt_inc); end
        n_chk++;

        // R8: no-source type values with every event asserted
        set_types(8'd8, 8'h80, 8'hFD, 8'hFF);
        drive_all(); tick();
        check("R8 no source", '0);

        // R9: cycle lane strobes with no events
        set_types(8'hFF, 8'hFF, 8'hFF, 8'hFE);
        drive_evt(0, 0, 1'b0, 3'b000, 2'b00, 1'b0);
        for (int i = 0; i < 3; i++) begin tick(); check("R9 cycles", 4'b1000); end

        // R7: clear enable in the same cycle the cycle lane is live
        wr_reg(12'h410, 8'h80, 64'd0);
        check("R7 write cycle still counts", 4'b1000);
        drive_all(); tick();
        check("R7 disabled", '0);
        set_types(8'd1, 8'd1, 8'hFE, 8'hFE);
        drive_all(); tick();
        check("R7 disabled all", '0);
        wr_reg(12'h410, 8'h80, 64'h8000_0000_0000_0000);
        evt_check("R7 re-enabled", 1, 8'h21, 3'b001, 2'b01, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule